// File: doc/BRIEF.md
# Bit-Serial ALU Word Checker

This block is a synthesizable monitor that sits next to a bit-serial ALU. The ALU handles one operand bit per clock and keeps a carry between clocks. The monitor watches the ALU's active-low frame reset, its 3-bit opcode, the serial operand bits and the serial result bit. Each word is framed by reset. A low cycle presets the ALU's carry for the coming opcode. The active window that follows carries the word one bit per clock, least significant bit first. When reset drops again, the monitor rebuilds the operands and the result as whole words and checks the result against the arithmetic the opcode calls for.

The monitor also checks the framing. The opcode seen in the reset cycle must hold through every active cycle of the word. The active window must be exactly one word long. Every result is reported as a one-cycle check pulse, together with flags and the expected and observed words, so that debug logic or a scoreboard can pick it up.

Top module: `serial_alu_checker`

## Requirements
- R1: While the monitor's own reset `rst_n` is low, all outputs are 0 on the next clock and stay 0.
- R2: `check_valid` pulses high for exactly one cycle, registered on the first clock edge that samples `alu_rst_n` low after one or more active edges. Consecutive low samples with no active edge between them produce no pulse.
- R3: Serial bits arrive least significant bit first. In `obs_word`, bit i is the `bit_y` sampled on the i-th active edge of the word, counting from 0.
- R4: For the recorded opcode 3'b000 (add), `exp_word` is (A + B) mod 256. A and B are the captured operand words.
- R5: For the recorded opcode 3'b001 (subtract), `exp_word` is (A - B) mod 256. A serial subtractor therefore needs a carry-in of 1 on its first bit.
- R6: On a checked frame of length 8, `mismatch` is high with `check_valid` exactly when `obs_word` differs from `exp_word`.
- R7: The recorded opcode is the one sampled on the first active edge. If the reset cycle used a different opcode and so preset the wrong carry, the resulting off-by-one word raises `mismatch`.
- R8: `proto_err` is high in the cycle after each active edge whose opcode differs from the opcode sampled on the most recent reset-low edge.
- R9: If the number of active edges in a frame is not 8, `len_err` is high with `check_valid`, and `mismatch` stays low for that frame.
- R10: Recorded opcodes other than 3'b000 and 3'b001 set `unchecked` with `check_valid`, and `mismatch` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the monitored ALU |
| rst_n | input | 1 | Active-low reset of the monitor itself |
| alu_rst_n | input | 1 | Active-low frame reset of the ALU; a low cycle marks a word boundary |
| op | input | 3 | ALU opcode |
| bit_a | input | 1 | Serial operand A bit |
| bit_b | input | 1 | Serial operand B bit |
| bit_y | input | 1 | Serial result bit produced by the ALU |
| check_valid | output | 1 | One-cycle pulse: a frame result is reported |
| mismatch | output | 1 | The result word differs from the expected word |
| proto_err | output | 1 | The opcode moved away from its reset-cycle value on the previous active edge |
| len_err | output | 1 | The reported frame did not have exactly 8 active cycles |
| unchecked | output | 1 | The reported frame used an opcode with no arithmetic check |
| exp_word | output | 8 | Expected result word of the last reported frame |
| obs_word | output | 8 | Observed result word of the last reported frame |

## Verification
A bad active-cycle count shows up at the frame boundary that follows. The pulse either goes missing or comes out twice, or `len_err` is raised on a well-formed word, one clock after reset drops. A stale opcode reference shows up one cycle after the first active edge as a false or missing `proto_err`. A wrong shift direction or a wrong recorded opcode stays hidden inside the word and surfaces only at the boundary pulse, as wrong `obs_word` or `exp_word` values or a false `mismatch`. The bench therefore compares every output on every clock against a behavioural model driven by its own serial ALU. The model also injects a stale carry preset and single flipped result bits.

// File: rtl/salu_chk_pkg.sv
package salu_chk_pkg;
  localparam int OPW = 3;
  localparam logic [OPW-1:0] OP_ADD = 3'b000;
  localparam logic [OPW-1:0] OP_SUB = 3'b001;

  localparam int NLANES = 3;
  localparam int LANE_A = 0;
  localparam int LANE_B = 1;
  localparam int LANE_Y = 2;

  function automatic logic op_is_checked(logic [OPW-1:0] opc);
    return (opc == OP_ADD) || (opc == OP_SUB);
  endfunction
endpackage

// File: rtl/salu_frame_track.sv
module salu_frame_track #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alu_rst_n,
  output logic active,
  output logic first_active,
  output logic frame_end,
  output logic len_bad
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt;

  assign active       = alu_rst_n;
  assign first_active = alu_rst_n && (cnt == '0);
  assign frame_end    = !alu_rst_n && (cnt != '0);
  assign len_bad      = (cnt != CW'(W));

  always_ff @(posedge clk) begin
    if (!rst_n || !alu_rst_n) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/salu_shift_lane.sv
module salu_shift_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  // Least significant bit first: new bits enter at the top.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {bit_in, word[W-1:1]};
    end
  end
endmodule

// File: rtl/salu_op_guard.sv
module salu_op_guard
  import salu_chk_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alu_rst_n,
  input  logic           first_active,
  input  logic [OPW-1:0] op,
  output logic [OPW-1:0] op_word,
  output logic           op_changed
);
  logic [OPW-1:0] op_ref;

  assign op_changed = alu_rst_n && (op != op_ref);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_ref  <= '0;
      op_word <= '0;
    end else begin
      if (!alu_rst_n) op_ref <= op;
      if (first_active) op_word <= op;
    end
  end
endmodule

// File: rtl/serial_alu_checker.sv
module serial_alu_checker
  import salu_chk_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alu_rst_n,
  input  logic [2:0]   op,
  input  logic         bit_a,
  input  logic         bit_b,
  input  logic         bit_y,
  output logic         check_valid,
  output logic         mismatch,
  output logic         proto_err,
  output logic         len_err,
  output logic         unchecked,
  output logic [W-1:0] exp_word,
  output logic [W-1:0] obs_word
);
  function automatic logic [W-1:0] ref_word(logic [OPW-1:0] opc,
                                            logic [W-1:0] wa,
                                            logic [W-1:0] wb);
    case (opc)
      OP_ADD:  return wa + wb;
      OP_SUB:  return wa + ~wb + W'(1);
      default: return '0;
    endcase
  endfunction

  logic           active;
  logic           first_active;
  logic           frame_end;
  logic           len_bad;
  logic           op_changed;
  logic [OPW-1:0] op_word;
  logic [NLANES-1:0] lane_bits;
  logic [W-1:0]   lane_word [NLANES];
  logic [W-1:0]   exp_calc;
  logic           op_ok;

  assign lane_bits = {bit_y, bit_b, bit_a};

  salu_frame_track #(.W(W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .alu_rst_n    (alu_rst_n),
    .active       (active),
    .first_active (first_active),
    .frame_end    (frame_end),
    .len_bad      (len_bad)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    salu_shift_lane #(.W(W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (active),
      .bit_in   (lane_bits[g]),
      .word     (lane_word[g])
    );
  end

  salu_op_guard u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .alu_rst_n    (alu_rst_n),
    .first_active (first_active),
    .op           (op),
    .op_word      (op_word),
    .op_changed   (op_changed)
  );

  assign op_ok    = op_is_checked(op_word);
  assign exp_calc = ref_word(op_word, lane_word[LANE_A], lane_word[LANE_B]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      check_valid <= 1'b0;
      mismatch    <= 1'b0;
      proto_err   <= 1'b0;
      len_err     <= 1'b0;
      unchecked   <= 1'b0;
      exp_word    <= '0;
      obs_word    <= '0;
    end else begin
      check_valid <= frame_end;
      proto_err   <= op_changed;
      if (frame_end) begin
        len_err   <= len_bad;
        unchecked <= !op_ok;
        mismatch  <= !len_bad && op_ok && (exp_calc != lane_word[LANE_Y]);
        exp_word  <= exp_calc;
        obs_word  <= lane_word[LANE_Y];
      end else begin
        len_err   <= 1'b0;
        unchecked <= 1'b0;
        mismatch  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_alu_checker_sva.sv
module serial_alu_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       alu_rst_n,
  input logic [2:0] op,
  input logic       frame_end,
  input logic       check_valid,
  input logic       mismatch,
  input logic       proto_err,
  input logic       len_err,
  input logic       unchecked
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!check_valid && !mismatch && !proto_err && !len_err && !unchecked));

  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    check_valid |=> !check_valid);

  a_r2_valid_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> check_valid);

  a_r2_valid_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    check_valid |-> !$past(alu_rst_n));

  a_r6_mismatch_in_check: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> check_valid);

  a_r8_first_edge_change: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_rst_n && !$past(alu_rst_n) && (op != $past(op))) |=> proto_err);

  a_r8_only_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(alu_rst_n));

  a_r9_len_suppresses: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> (check_valid && !mismatch));

  a_r10_unchecked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    unchecked |-> (check_valid && !mismatch));
endmodule

bind serial_alu_checker serial_alu_checker_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .alu_rst_n   (alu_rst_n),
  .op          (op),
  .frame_end   (frame_end),
  .check_valid (check_valid),
  .mismatch    (mismatch),
  .proto_err   (proto_err),
  .len_err     (len_err),
  .unchecked   (unchecked)
);

// File: tb/serial_alu_checker_tb.sv
module serial_alu_checker_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alu_rst_n = 1'b0;
  logic [2:0] op = 3'b000;
  logic       bit_a = 1'b0;
  logic       bit_b = 1'b0;
  logic       bit_y = 1'b0;
  logic       check_valid, mismatch, proto_err, len_err, unchecked;
  logic [7:0] exp_word, obs_word;

  int n_chk = 0;
  int n_fail = 0;
  int mis_seen = 0;
  int proto_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_alu_checker u_dut (
    .clk(clk), .rst_n(rst_n), .alu_rst_n(alu_rst_n), .op(op),
    .bit_a(bit_a), .bit_b(bit_b), .bit_y(bit_y),
    .check_valid(check_valid), .mismatch(mismatch), .proto_err(proto_err),
    .len_err(len_err), .unchecked(unchecked),
    .exp_word(exp_word), .obs_word(obs_word)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, evaluated on every clock.
  int   m_cnt = 0;
  int   m_op_ref = 0;
  int   m_op_word = 0;
  logic qa[$];
  logic qb[$];
  logic qy[$];
  bit   e_valid, e_proto, e_len, e_unchk, e_mis;
  int   e_exp, e_obs;

  function automatic int q_word(input logic q[$]);
    int v = 0;
    foreach (q[i]) if (i < 8 && q[i]) v += (1 << i);
    return v;
  endfunction

  always @(posedge clk) begin
    int wa, wb;
    e_valid = 0; e_proto = 0; e_len = 0; e_unchk = 0; e_mis = 0;
    if (!rst_n) begin
      m_cnt = 0; m_op_ref = 0; m_op_word = 0;
      qa.delete(); qb.delete(); qy.delete();
    end else if (!alu_rst_n) begin
      if (m_cnt > 0) begin
        e_valid = 1;
        e_len   = (m_cnt != 8);
        wa = q_word(qa); wb = q_word(qb);
        e_obs = q_word(qy);
        e_unchk = !(m_op_word == 0 || m_op_word == 1);
        if (m_op_word == 0) e_exp = (wa + wb) % 256;
        else if (m_op_word == 1) e_exp = (wa - wb + 256) % 256;
        else e_exp = 0;
        e_mis = !e_len && !e_unchk && (e_exp != e_obs);
      end
      m_cnt = 0; m_op_ref = int'(op);
      qa.delete(); qb.delete(); qy.delete();
    end else begin
      if (m_cnt == 0) m_op_word = int'(op);
      e_proto = (int'(op) != m_op_ref);
      qa.push_back(bit_a); qb.push_back(bit_b); qy.push_back(bit_y);
      if (m_cnt < 15) m_cnt++;
    end
    #2;
    chk("R2 check_valid", int'(check_valid), int'(e_valid));
    chk("R8 proto_err", int'(proto_err), int'(e_proto));
    if (mismatch) mis_seen++;
    if (proto_err) proto_seen++;
    if (e_valid) begin
      chk("R9 len_err", int'(len_err), int'(e_len));
      chk("R10 unchecked", int'(unchecked), int'(e_unchk));
      chk("R6 mismatch", int'(mismatch), int'(e_mis));
      if (!e_len) begin
        chk("R3 obs_word", int'(obs_word), e_obs);
        if (m_op_word == 0) chk("R4 exp_word add", int'(exp_word), e_exp);
        if (m_op_word == 1) chk("R5 exp_word sub", int'(exp_word), e_exp);
      end
    end else begin
      chk("R2 mismatch idle", int'(mismatch), 0);
    end
  end

  // Serial ALU model driving the monitored bits.
  logic carry = 1'b0;

  task automatic frame(input logic [2:0] rop, input logic [2:0] aop,
                       input logic [7:0] a, input logic [7:0] b,
                       input int n, input int chg_at, input logic [2:0] chg_op,
                       input int flip_at);
    @(negedge clk);
    alu_rst_n = 1'b0; op = rop; bit_a = 0; bit_b = 0; bit_y = 0;
    carry = (rop == 3'b001);
    for (int i = 0; i < n; i++) begin
      logic [2:0] cur;
      logic ai, bi, yv;
      @(negedge clk);
      cur = (chg_at >= 0 && i >= chg_at) ? chg_op : aop;
      alu_rst_n = 1'b1; op = cur;
      ai = a[i % 8];
      bi = b[i % 8] ^ (cur == 3'b001);
      yv = ai ^ bi ^ carry;
      if (i == flip_at) yv = ~yv;
      bit_a = a[i % 8]; bit_b = b[i % 8]; bit_y = yv;
      carry = (ai & bi) | (ai & carry) | (bi & carry);
    end
  endtask

  task automatic idle(input int n, input logic [2:0] o);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      alu_rst_n = 1'b0; op = o;
    end
  endtask

  initial begin
    int m0, p0;
    repeat (3) @(negedge clk);
    chk("R1 check_valid in reset", int'(check_valid), 0);
    chk("R1 flags in reset", int'({mismatch, proto_err, len_err, unchecked}), 0);
    chk("R1 words in reset", int'({exp_word, obs_word}), 0);
    rst_n = 1'b1;
    idle(3, 3'b000);                                   // R2: no pulse
    frame(3'b000, 3'b000, 8'd29,  8'd150, 8, -1, 3'b000, -1);  // R4
    frame(3'b000, 3'b000, 8'd255, 8'd1,   8, -1, 3'b000, -1);
    frame(3'b000, 3'b000, 8'd170, 8'd85,  8, -1, 3'b000, -1);
    frame(3'b001, 3'b001, 8'd29,  8'd150, 8, -1, 3'b000, -1);  // R5
    frame(3'b001, 3'b001, 8'd0,   8'd1,   8, -1, 3'b000, -1);
    frame(3'b001, 3'b001, 8'd200, 8'd100, 8, -1, 3'b000, -1);
    idle(2, 3'b001);
    m0 = mis_seen;
    frame(3'b000, 3'b000, 8'd77,  8'd33,  8, -1, 3'b000, 3);    // R6 flip
    idle(2, 3'b000);
    chk("R6 flipped bit raised mismatch", int'(mis_seen > m0), 1);
    frame(3'b011, 3'b011, 8'd12,  8'd34,  8, -1, 3'b000, -1);  // R10
    frame(3'b000, 3'b000, 8'd5,   8'd6,   7, -1, 3'b000, -1);  // R9 short
    frame(3'b000, 3'b000, 8'd5,   8'd6,   9, -1, 3'b000, -1);  // R9 long
    frame(3'b001, 3'b000, 8'd9,   8'd3,   8, 4, 3'b001, -1);   // R8 mid-word
    idle(2, 3'b000);
    m0 = mis_seen; p0 = proto_seen;
    frame(3'b110, 3'b001, 8'd29,  8'd150, 8, -1, 3'b000, -1);  // R7 stale preset
    idle(2, 3'b000);
    chk("R7 stale carry preset raised mismatch", int'(mis_seen > m0), 1);
    chk("R7 stale carry preset raised proto_err", int'(proto_seen > p0), 1);
    frame(3'b001, 3'b001, 8'd100, 8'd7,   8, -1, 3'b000, -1);
    idle(3, 3'b000);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule